// File: doc/BRIEF.md
# Coalescing Line Write Buffer

This block sits between a processor core and its second-level cache and absorbs stores. Each slot holds a whole cache line with one valid bit per byte. A store to a line that already has a slot writes its bytes into that slot. A store to any other line opens a new slot. Loads look into the buffer first. If every requested byte is present, the load is answered in the same cycle. If the line is buffered but some requested bytes are missing, the load is held off. If the line is not buffered at all, the load is left to the cache.

Slots drain lazily. A line is offered downstream only while the number of occupied slots is at or above a retire threshold, and lines leave oldest first over a valid/ready line-write port. A flush pulse overrides the threshold and empties the buffer, then reports completion with a one-cycle done pulse. Addresses on the processor side are word addresses. The line address is the word address with its word-select bits removed.

Top module: `coalesce_wbuf`

## Requirements
- R1: After reset the buffer is empty: dn_valid, st_stall, ld_hit, ld_stall and flush_done are all 0.
- R2: A store whose line is not buffered takes a new slot. A store whose line is buffered writes its enabled bytes into that slot and takes no slot. Newer bytes replace older ones.
- R3: With DEPTH slots occupied, a store to an unbuffered line holds st_stall high and is not taken. A store that merges into a slot other than the one being offered is still taken without stall.
- R4: Without a flush, dn_valid is high exactly while occupancy is at least RETIRE_AT. Draining stops once occupancy falls to RETIRE_AT-1.
- R5: Lines leave in allocation order, oldest first. Each line carries its line address, the line data (byte k on bits 8k+7..8k), and a mask whose bit k marks byte k as written. Unwritten bytes read as zero.
- R6: While dn_valid is high and dn_ready is low, dn_valid stays high and dn_line_addr, dn_data and dn_mask hold their values.
- R7: A load whose requested bytes (ld_be, bit b = byte b of the word) are all valid in the buffered line raises ld_hit in the same cycle. ld_data returns those bytes, and lanes that were not requested read as zero.
- R8: A load to a buffered line with any requested byte missing raises ld_stall and not ld_hit. A load to an unbuffered line raises neither.
- R9: A one-cycle flush pulse retires every slot regardless of the threshold. flush_done pulses for one cycle after the buffer becomes empty. On an already empty buffer it pulses on the cycle after the flush.
- R10: A store to the line currently offered downstream stalls. Once that line has retired, the store is taken into a new slot.
- R11: A load sees the buffer as it was before a store presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_waddr | input | ADDR_W-2 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_stall | output | 1 | Store not taken this cycle |
| ld_valid | input | 1 | Load request |
| ld_waddr | input | ADDR_W-2 | Load word address |
| ld_be | input | 4 | Requested bytes |
| ld_hit | output | 1 | Load fully served by the buffer |
| ld_stall | output | 1 | Line buffered but bytes missing |
| ld_data | output | 32 | Forwarded word |
| dn_valid | output | 1 | Line offered downstream |
| dn_ready | input | 1 | Downstream accepts the line |
| dn_line_addr | output | ADDR_W-log2(LINE_BYTES) | Line address |
| dn_data | output | LINE_BYTES*8 | Line data |
| dn_mask | output | LINE_BYTES | Written-byte mask |
| flush | input | 1 | Pulse: drain everything |
| flush_done | output | 1 | One-cycle pulse, buffer empty after flush |

## Verification
Two pairs of functions can land in the same cycle. In one, a store targets the very line that is being offered downstream. In the other, a load and a store present the same word together. The first is provoked by reaching the threshold with dn_ready low and then storing to the head line: st_stall must rise, the offered line must stay stable, and the retired line must not carry the new bytes. In the second, store and load are driven in one cycle to a word with no valid bytes. The load must report a stall that cycle and a hit with the new data on the next, and a scoreboard of expected lines judges every downstream transfer.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    LD_MISS = 2'd0,
    LD_HIT  = 2'd1,
    LD_WAIT = 2'd2
  } ld_res_e;
endpackage

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int N     = 26,
  parameter int TAG_W = 27
) (
  input  logic [N-1:0]         ent_valid,
  input  logic [TAG_W-1:0]     ent_tag [N],
  input  logic [TAG_W-1:0]     probe,
  output logic [N-1:0]         hit_vec,
  output logic                 hit,
  output logic [$clog2(N)-1:0] hit_idx
);
  localparam int IDX_W = $clog2(N);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_tag[g] == probe);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [LINE_BYTES-1:0][7:0]                  line_data,
  input  logic [LINE_BYTES-1:0]                       line_mask,
  input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0]    word_idx,
  input  logic [WORD_BYTES-1:0]                       be,
  output logic [WORD_BYTES*8-1:0]                     word,
  output logic                                        covered
);
  always_comb begin
    word    = '0;
    covered = 1'b1;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (be[b]) begin
        word[b*8 +: 8] = line_data[int'(word_idx)*WORD_BYTES + b];
        if (!line_mask[int'(word_idx)*WORD_BYTES + b]) covered = 1'b0;
      end
    end
  end
endmodule

// File: rtl/wbuf_ring.sv
module wbuf_ring #(
  parameter int DEPTH     = 26,
  parameter int RETIRE_AT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc,
  input  logic                       retire,
  input  logic                       flush_req,
  output logic [$clog2(DEPTH)-1:0]   head,
  output logic [$clog2(DEPTH)-1:0]   tail,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       drain_ok,
  output logic                       flush_done
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic             flushing;
  logic [CNT_W-1:0] count_nxt;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign count_nxt = count + CNT_W'(alloc) - CNT_W'(retire);
  assign full      = (count == CNT_W'(DEPTH));
  assign drain_ok  = (count != '0) && ((count >= CNT_W'(RETIRE_AT)) || flushing);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head       <= '0;
      tail       <= '0;
      count      <= '0;
      flushing   <= 1'b0;
      flush_done <= 1'b0;
    end else begin
      if (alloc)  tail <= wrap_inc(tail);
      if (retire) head <= wrap_inc(head);
      count      <= count_nxt;
      flush_done <= 1'b0;
      if ((flush_req || flushing) && count_nxt == '0) begin
        flushing   <= 1'b0;
        flush_done <= 1'b1;
      end else if (flush_req) begin
        flushing <= 1'b1;
      end
    end
  end

  // R3: no slot is opened when all are taken
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> count < CNT_W'(DEPTH));

  // R5: nothing leaves an empty ring
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> count != '0);

  // R4: draining pauses once occupancy drops below the threshold
  p_retire_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !alloc && !flushing && !flush_req && count == CNT_W'(RETIRE_AT))
      |=> !drain_ok);

  // R9: completion is only reported on an empty ring
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (count == '0 && !flushing));
endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf import wbuf_pkg::*; #(
  parameter  int ADDR_W     = 32,
  parameter  int LINE_BYTES = 32,
  parameter  int DEPTH      = 26,
  parameter  int RETIRE_AT  = 4,
  localparam int WADDR_W    = ADDR_W - $clog2(WORD_BYTES),
  localparam int TAG_W      = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  input  logic [WADDR_W-1:0]      st_waddr,
  input  logic [WORD_BYTES*8-1:0] st_data,
  input  logic [WORD_BYTES-1:0]   st_be,
  output logic                    st_stall,
  input  logic                    ld_valid,
  input  logic [WADDR_W-1:0]      ld_waddr,
  input  logic [WORD_BYTES-1:0]   ld_be,
  output logic                    ld_hit,
  output logic                    ld_stall,
  output logic [WORD_BYTES*8-1:0] ld_data,
  output logic                    dn_valid,
  input  logic                    dn_ready,
  output logic [TAG_W-1:0]        dn_line_addr,
  output logic [LINE_BYTES*8-1:0] dn_data,
  output logic [LINE_BYTES-1:0]   dn_mask,
  input  logic                    flush,
  output logic                    flush_done
);
  localparam int WORDS  = LINE_BYTES / WORD_BYTES;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH+1);

  // ---- address arithmetic ----
  function automatic logic [TAG_W-1:0] line_of(input logic [WADDR_W-1:0] wa);
    return wa[WADDR_W-1:WIDX_W];
  endfunction

  function automatic logic [WIDX_W-1:0] word_of(input logic [WADDR_W-1:0] wa);
    return wa[WIDX_W-1:0];
  endfunction

  function automatic logic [LINE_BYTES-1:0] lanes_of(input logic [WIDX_W-1:0] w,
                                                     input logic [WORD_BYTES-1:0] be);
    logic [LINE_BYTES-1:0] m;
    m = '0;
    for (int b = 0; b < WORD_BYTES; b++) m[int'(w)*WORD_BYTES + b] = be[b];
    return m;
  endfunction

  function automatic logic [LINE_BYTES-1:0][7:0] spread(input logic [WORD_BYTES*8-1:0] d);
    logic [LINE_BYTES-1:0][7:0] l;
    for (int k = 0; k < LINE_BYTES; k++) l[k] = d[(k % WORD_BYTES)*8 +: 8];
    return l;
  endfunction

  // ---- slot storage ----
  logic [DEPTH-1:0]           ent_valid;
  logic [TAG_W-1:0]           ent_tag  [DEPTH];
  logic [LINE_BYTES-1:0]      ent_mask [DEPTH];
  logic [LINE_BYTES-1:0][7:0] ent_data [DEPTH];

  // ---- ring control ----
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             full, drain_ok;

  // ---- named events ----
  logic                       st_hit, ld_hit_any;
  logic [DEPTH-1:0]           st_hit_vec, ld_hit_vec;
  logic [IDX_W-1:0]           st_hit_idx, ld_hit_idx;
  logic [TAG_W-1:0]           st_tag, ld_tag;
  logic [LINE_BYTES-1:0]      st_lanes;
  logic [LINE_BYTES-1:0][7:0] st_spread;
  logic                       head_blocked, merge_evt, alloc_evt, retire_fire;
  logic [WORD_BYTES*8-1:0]    fwd_word;
  logic                       fwd_covered;
  ld_res_e                    ld_res;

  assign st_tag    = line_of(st_waddr);
  assign ld_tag    = line_of(ld_waddr);
  assign st_lanes  = lanes_of(word_of(st_waddr), st_be);
  assign st_spread = spread(st_data);

  wbuf_match #(.N(DEPTH), .TAG_W(TAG_W)) u_st_match (
    .ent_valid(ent_valid), .ent_tag(ent_tag), .probe(st_tag),
    .hit_vec(st_hit_vec), .hit(st_hit), .hit_idx(st_hit_idx));

  wbuf_match #(.N(DEPTH), .TAG_W(TAG_W)) u_ld_match (
    .ent_valid(ent_valid), .ent_tag(ent_tag), .probe(ld_tag),
    .hit_vec(ld_hit_vec), .hit(ld_hit_any), .hit_idx(ld_hit_idx));

  wbuf_fwd #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_fwd (
    .line_data(ent_data[ld_hit_idx]), .line_mask(ent_mask[ld_hit_idx]),
    .word_idx(word_of(ld_waddr)), .be(ld_be),
    .word(fwd_word), .covered(fwd_covered));

  assign retire_fire  = dn_valid && dn_ready;
  assign head_blocked = st_hit && (st_hit_idx == head) && dn_valid;
  assign merge_evt    = st_valid && st_hit && !head_blocked;
  assign alloc_evt    = st_valid && !st_hit && !full;
  assign st_stall     = st_valid && !merge_evt && !alloc_evt;

  wbuf_ring #(.DEPTH(DEPTH), .RETIRE_AT(RETIRE_AT)) u_ring (
    .clk(clk), .rst_n(rst_n), .alloc(alloc_evt), .retire(retire_fire),
    .flush_req(flush), .head(head), .tail(tail), .count(count), .full(full),
    .drain_ok(drain_ok), .flush_done(flush_done));

  // ---- load answer ----
  always_comb begin
    if (!ld_valid || !ld_hit_any) ld_res = LD_MISS;
    else if (fwd_covered)         ld_res = LD_HIT;
    else                          ld_res = LD_WAIT;
  end

  assign ld_hit   = (ld_res == LD_HIT);
  assign ld_stall = (ld_res == LD_WAIT);
  assign ld_data  = ld_hit ? fwd_word : '0;

  // ---- downstream port ----
  assign dn_valid     = drain_ok;
  assign dn_line_addr = ent_tag[head];
  assign dn_data      = ent_data[head];
  assign dn_mask      = ent_mask[head];

  // ---- slot state ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_tag[i]  <= '0;
        ent_mask[i] <= '0;
      end
    end else begin
      if (retire_fire) ent_valid[head] <= 1'b0;
      if (alloc_evt) begin
        ent_valid[tail] <= 1'b1;
        ent_tag[tail]   <= st_tag;
        ent_mask[tail]  <= st_lanes;
      end
      if (merge_evt) ent_mask[st_hit_idx] <= ent_mask[st_hit_idx] | st_lanes;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_evt) begin
      for (int k = 0; k < LINE_BYTES; k++)
        ent_data[tail][k] <= st_lanes[k] ? st_spread[k] : 8'h00;
    end
    if (merge_evt) begin
      for (int k = 0; k < LINE_BYTES; k++)
        if (st_lanes[k]) ent_data[st_hit_idx][k] <= st_spread[k];
    end
  end

  // R2: a line lives in at most one slot
  p_unique_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_hit_vec) && $onehot0(ld_hit_vec));

  // R2: a merge leaves occupancy unchanged
  p_merge_no_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_evt && !retire_fire) |=> count == $past(count));

  // R3: a new line is refused while every slot is taken
  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_hit && count == CNT_W'(DEPTH)) |-> st_stall);

  // R6: an offered line is held until accepted
  p_dn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_line_addr)
                                  && $stable(dn_data) && $stable(dn_mask)));

  // R8: the two load answers never coincide
  p_ld_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_stall));
endmodule

// File: tb/coalesce_wbuf_tb.sv
`timescale 1ns/1ps
module coalesce_wbuf_tb;
  localparam int ADDR_W = 32, LB = 32, DEPTH = 26, RETIRE_AT = 4;
  localparam int WADDR_W = ADDR_W - 2;
  localparam int TAG_W = ADDR_W - 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0;
  logic [WADDR_W-1:0] st_waddr = '0;
  logic [31:0] st_data = '0;
  logic [3:0] st_be = '0;
  logic st_stall;
  logic ld_valid = 1'b0;
  logic [WADDR_W-1:0] ld_waddr = '0;
  logic [3:0] ld_be = '0;
  logic ld_hit, ld_stall;
  logic [31:0] ld_data;
  logic dn_valid;
  logic dn_ready = 1'b0;
  logic [TAG_W-1:0] dn_line_addr;
  logic [LB*8-1:0] dn_data;
  logic [LB-1:0] dn_mask;
  logic flush = 1'b0;
  logic flush_done;

  coalesce_wbuf #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .DEPTH(DEPTH), .RETIRE_AT(RETIRE_AT)) u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_waddr(st_waddr), .st_data(st_data),
    .st_be(st_be), .st_stall(st_stall), .ld_valid(ld_valid), .ld_waddr(ld_waddr),
    .ld_be(ld_be), .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_line_addr(dn_line_addr),
    .dn_data(dn_data), .dn_mask(dn_mask), .flush(flush), .flush_done(flush_done));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_popped = 0, rdy_mode = 0, last_stalls = 0;
  logic [TAG_W-1:0] m_tag [$];
  logic [LB*8-1:0]  m_dat [$];
  logic [LB-1:0]    m_msk [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected-line model: push a new line or merge into the buffered one
  task automatic model_store(input logic [31:0] ba, input logic [31:0] d, input logic [3:0] be);
    logic [TAG_W-1:0] t;
    int w, pos;
    logic [LB*8-1:0] line;
    logic [LB-1:0] msk;
    t = ba[31:5];
    w = int'(ba[4:2]);
    pos = -1;
    foreach (m_tag[i]) if (m_tag[i] == t) pos = i;
    if (pos < 0) begin line = '0; msk = '0; end
    else begin line = m_dat[pos]; msk = m_msk[pos]; end
    for (int b = 0; b < 4; b++) if (be[b]) begin
      line[(w*4+b)*8 +: 8] = d[b*8 +: 8];
      msk[w*4+b] = 1'b1;
    end
    if (pos < 0) begin m_tag.push_back(t); m_dat.push_back(line); m_msk.push_back(msk); end
    else begin m_dat[pos] = line; m_msk[pos] = msk; end
  endtask

  task automatic do_store(input logic [31:0] ba, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    st_valid = 1'b1; st_waddr = ba[31:2]; st_data = d; st_be = be;
    last_stalls = 0;
    forever begin
      @(negedge clk);
      if (!st_stall) break;
      last_stalls++;
    end
    model_store(ba, d, be);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic try_stalled_store(input logic [31:0] ba, input string req, input string what);
    @(posedge clk); #1;
    st_valid = 1'b1; st_waddr = ba[31:2]; st_data = 32'h0BAD0BAD; st_be = 4'hF;
    @(negedge clk);
    chk(st_stall == 1'b1, req, what, st_stall, 1);
    #1 st_valid = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] ba, input logic [3:0] be, input bit e_hit,
                         input bit e_stall, input logic [31:0] e_data, input string req);
    @(posedge clk); #1;
    ld_valid = 1'b1; ld_waddr = ba[31:2]; ld_be = be;
    @(negedge clk);
    chk(ld_hit == e_hit, req, "ld_hit", ld_hit, e_hit);
    chk(ld_stall == e_stall, req, "ld_stall", ld_stall, e_stall);
    if (e_hit) chk(ld_data == e_data, req, "ld_data", ld_data, e_data);
    #1 ld_valid = 1'b0;
  endtask

  // downstream ready pattern: 0 low, 1 high, 2 alternating
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: dn_ready = 1'b0;
      1: dn_ready = 1'b1;
      default: dn_ready = ~dn_ready;
    endcase
  end

  // monitor: every accepted line is compared with the oldest expected one (R5)
  always @(negedge clk) begin
    if (rst_n && dn_valid && dn_ready) begin
      if (m_tag.size() == 0) chk(1'b0, "R5", "line with nothing expected", dn_line_addr, 0);
      else begin
        chk(dn_line_addr == m_tag[0], "R5", "line address order", dn_line_addr, m_tag[0]);
        chk(dn_data == m_dat[0], "R5", "line data", dn_data, m_dat[0]);
        chk(dn_mask == m_msk[0], "R5", "byte mask", dn_mask, m_msk[0]);
        void'(m_tag.pop_front()); void'(m_dat.pop_front()); void'(m_msk.pop_front());
        n_popped++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  localparam logic [31:0] A = 32'h0000_1000, B = 32'h0000_2040, C = 32'h0000_3000,
                          D = 32'h0000_4020;

  initial begin
    logic [LB*8-1:0] held_data;
    logic [TAG_W-1:0] held_addr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dn_valid == 0 && flush_done == 0, "R1", "outputs in reset", {dn_valid, flush_done}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(dn_valid == 0, "R1", "dn_valid after reset", dn_valid, 0);
    chk(st_stall == 0 && ld_hit == 0 && ld_stall == 0 && flush_done == 0, "R1",
        "idle outputs", {st_stall, ld_hit, ld_stall, flush_done}, 0);

    // R2: three stores to A coalesce, B and C open slots
    do_store(A,       32'h11223344, 4'hF);
    do_store(A,       32'h000000AA, 4'h1);
    do_store(A + 4,   32'h55667788, 4'h3);
    do_store(B + 8,   32'hCAFEF00D, 4'hF);
    do_store(C + 28,  32'h01020304, 4'hC);
    @(negedge clk);
    chk(dn_valid == 0, "R2", "merged stores took no extra slot (3 lines)", dn_valid, 0);
    chk(dn_valid == 0, "R4", "below threshold no drain", dn_valid, 0);

    // R7 / R8: load variants
    do_load(A,      4'hF, 1, 0, 32'h112233AA, "R7");
    do_load(A + 4,  4'h3, 1, 0, 32'h00007788, "R7");
    do_load(C + 28, 4'h8, 1, 0, 32'h01000000, "R7");
    do_load(A + 4,  4'hF, 0, 1, 32'h0, "R8");
    do_load(32'h0000_9000, 4'hF, 0, 0, 32'h0, "R8");

    // R11: store and load the same word in one cycle
    @(posedge clk); #1;
    st_valid = 1'b1; st_waddr = A[31:2] + 3; st_data = 32'hDEADBEEF; st_be = 4'hF;
    ld_valid = 1'b1; ld_waddr = A[31:2] + 3; ld_be = 4'hF;
    @(negedge clk);
    chk(ld_stall == 1 && ld_hit == 0, "R11", "load sees pre-store line", {ld_stall, ld_hit}, 2'b10);
    chk(st_stall == 0, "R11", "concurrent store taken", st_stall, 0);
    model_store(A + 12, 32'hDEADBEEF, 4'hF);
    @(posedge clk); #1 st_valid = 1'b0;
    @(negedge clk);
    chk(ld_hit == 1, "R11", "load hits next cycle", ld_hit, 1);
    chk(ld_data == 32'hDEADBEEF, "R11", "forwarded data", ld_data, 32'hDEADBEEF);
    #1 ld_valid = 1'b0;

    // R4: fourth line reaches the threshold
    do_store(D, 32'h0000BEEF, 4'h3);
    @(negedge clk);
    chk(dn_valid == 1, "R4", "drain at threshold", dn_valid, 1);
    chk(dn_line_addr == A[31:5], "R5", "oldest line offered", dn_line_addr, A[31:5]);
    held_data = dn_data; held_addr = dn_line_addr;
    @(negedge clk);
    chk(dn_valid == 1 && dn_data == held_data && dn_line_addr == held_addr, "R6",
        "offered line held", dn_data, held_data);

    // R10: store to the offered line stalls; R3: merge elsewhere still taken
    try_stalled_store(A + 16, "R10", "store to offered line");
    do_store(B + 12, 32'h99887766, 4'hF);
    chk(last_stalls == 0, "R3", "merge into non-head slot without stall", last_stalls, 0);

    // R4: one acceptance drops occupancy to 3 and draining stops
    @(negedge clk); rdy_mode = 1;
    @(negedge clk); rdy_mode = 0;
    @(negedge clk);
    chk(n_popped == 1, "R4", "exactly one line retired", n_popped, 1);
    chk(dn_valid == 0, "R4", "drain stops below threshold", dn_valid, 0);

    // R10: after retirement the store to A opens a new slot
    do_store(A + 16, 32'h12345678, 4'hF);
    chk(last_stalls == 0, "R10", "store after retire accepted", last_stalls, 0);

    // R3: fill every slot
    for (int i = 0; i < DEPTH - 4; i++) do_store(32'h0001_0000 + i*32, i, 4'hF);
    @(negedge clk);
    chk(dn_valid == 1, "R3", "full buffer offers line", dn_valid, 1);
    try_stalled_store(32'h0007_0000, "R3", "new line while full");
    do_store(C, 32'h0A0B0C0D, 4'hF);
    chk(last_stalls == 0, "R3", "merge while full", last_stalls, 0);

    // R9: flush with an alternating ready
    @(negedge clk); rdy_mode = 2;
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (flush_done) break;
    end
    chk(flush_done == 1, "R9", "flush_done raised", flush_done, 1);
    chk(m_tag.size() == 0, "R9", "all lines drained", m_tag.size(), 0);
    chk(dn_valid == 0, "R9", "nothing offered after flush", dn_valid, 0);
    @(negedge clk);
    chk(flush_done == 0, "R9", "done is one cycle", flush_done, 0);
    rdy_mode = 0;
    chk(n_popped == DEPTH + 1, "R5", "total lines retired", n_popped, DEPTH + 1);

    // R9: flush on an empty buffer
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    chk(flush_done == 1, "R9", "empty flush done next cycle", flush_done, 1);
    @(negedge clk);
    chk(flush_done == 0, "R9", "empty flush done pulse", flush_done, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule